// File: doc/BRIEF.md
# Radix-4 Partial Product Generator with Folded Negation

This combinational block turns a pair of signed operands into the partial products of a radix-4 multiplication, ready for a reduction array that works from the most significant row downward. The multiplier operand is split into overlapping three-bit windows. Each window is decoded into a signed digit in the range -2..+2, carried as three controls: invert, double and single. The multiplicand is inverted first and then routed as 1X or 2X. A zero digit clears the row body whatever the invert control says.

The "+1" that completes a negation is not kept as a loose bit at the row's LSB. It is folded into the row's lowest bit, and what is left over becomes a correction bit one position higher. Both of these bits are as shallow as any other row bit. Sign extension uses an inverted top bit on each row plus one shared constant vector. Adding every row, every correction bit and the constant therefore gives the exact two's-complement product. Downstream reduction and the final adder sit outside this block.

Top module: `radix4_pp_gen`

## Requirements
- R1: With `W` the (even) operand width, there are `W/2` rows. Row `i` decodes the window `y[2i+1], y[2i], y[2i-1]` (with `y[-1]` = 0) into the digit `d = -2*y[2i+1] + y[2i] + y[2i-1]`.
- R2: Let `v` be the (W+1)-bit two's-complement value `d*X - 2*c`, where `c` is the row's correction bit. The row's bits `W-1..0` equal bits `W-1..0` of `v`, and row bit `W` equals the inverse of bit `W` of `v`.
- R3: A zero digit, from window 000 or 111, gives a row of 1 followed by `W` zeros and a correction bit of 0, whatever the invert control is.
- R4: Bit 0 of row `i` equals `x[0] AND (y[2i] XOR y[2i-1])`.
- R5: The correction bit of row `i` is `(y[2i+1] & ~y[2i] & ~y[2i-1]) | (y[2i+1] & ~x[0] & (y[2i] ^ y[2i-1]))`. It has weight `2^(2i+1)`, so it is 1 exactly for digit -2, and for digit -1 when `x[0]` is 0.
- R6: The constant output equals `2^(2W)` minus the sum of `2^(W+2i)` over all rows, taken modulo `2^(2W)`.
- R7: Rows are listed most significant first. Output index `k` carries row `i = W/2-1-k`, which has weight `4^i`. The correction vector uses the same index order.
- R8: Each row shifted left by `2i`, plus each correction bit at weight `2^(2i+1)`, plus the constant, summed modulo `2^(2W)`, equals `X*Y` modulo `2^(2W)`. This holds for every operand pair, including the most negative values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| x_in | input | W | Signed multiplicand |
| y_in | input | W | Signed multiplier, recoded in overlapping windows |
| pp_rows | output | (W/2)*(W+1) | Packed rows, most significant row at index 0 |
| pp_corr | output | W/2 | Correction bits, same index order as the rows |
| pp_bias | output | 2W | Shared sign-extension constant |

## Verification
Within one row, the folded LSB and the correction bit both react to the same window in the same evaluation. A digit of -1 with an even multiplicand must therefore clear the merged LSB and raise the correction bit together, while an odd multiplicand must leave the correction bit low. The bench provokes this by sweeping every operand pair at width 8, so every window meets both parities of `x[0]`. At width 16 it covers the corner values and random pairs. It judges each row against the value `d*X - 2*c` computed arithmetically, and it judges the full sum against the integer product.

// File: rtl/radix4_pp_pkg.sv
package radix4_pp_pkg;

    // Digit controls for one recoded window of the multiplier.
    typedef struct packed {
        logic neg;   // invert the multiplicand
        logic two;   // select doubled multiplicand
        logic one;   // select plain multiplicand
    } digit_ctl_t;

endpackage

// File: rtl/radix4_digit_decode.sv
module radix4_digit_decode
    import radix4_pp_pkg::*;
(
    input  logic [2:0]  window_i,
    output digit_ctl_t  ctl_o
);

    digit_ctl_t ctl_d;

    always_comb begin
        ctl_d.neg = window_i[2];
        ctl_d.one = window_i[1] ^ window_i[0];
        ctl_d.two = ( window_i[2] & ~window_i[1] & ~window_i[0]) |
                    (~window_i[2] &  window_i[1] &  window_i[0]);
    end

    assign ctl_o = ctl_d;

    // Select lines must never both be active.
    always_comb begin
        AST_SEL_EXCLUSIVE: assert (!(ctl_d.two && ctl_d.one))
            else $error("double and single selected together"); // R1
    end

endmodule

// File: rtl/radix4_row_build.sv
module radix4_row_build
    import radix4_pp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] x_i,
    input  digit_ctl_t   ctl_i,
    output logic [W:0]   row_o,
    output logic         corr_o
);

    localparam int EXT = W + 1;

    logic [EXT-1:0] x_ext;
    logic [EXT-1:0] x_inv;
    logic [W-1:0]   upper_d;   // row bits W..1 before sign handling
    logic           lsb_d;
    logic           corr_d;

    always_comb begin
        x_ext = {x_i[W-1], x_i};
        // Invert first, pick magnitude second.
        x_inv = x_ext ^ {EXT{ctl_i.neg}};
        if (ctl_i.one) begin
            upper_d = x_inv[W:1];
        end else if (ctl_i.two) begin
            upper_d = x_inv[W-1:0];
        end else begin
            upper_d = '0;
        end
        // Negation's +1 folded into bit 0, remainder pushed up one place.
        lsb_d  = x_i[0] & ctl_i.one;
        corr_d = (ctl_i.neg & ctl_i.two) |
                 (ctl_i.neg & ~x_i[0] & ctl_i.one);
    end

    assign row_o  = {~upper_d[W-1], upper_d[W-2:0], lsb_d};
    assign corr_o = corr_d;

    always_comb begin
        if (!ctl_i.two && !ctl_i.one) begin
            AST_ZERO_DIGIT: assert (row_o == {1'b1, {W{1'b0}}} && !corr_o)
                else $error("zero digit left residue"); // R3
        end
        if (corr_o) begin
            AST_CORR_NEEDS_NEG: assert (ctl_i.neg)
                else $error("correction raised on positive digit"); // R5
        end
        if (row_o[0]) begin
            AST_LSB_NEEDS_ONE: assert (ctl_i.one && x_i[0])
                else $error("merged LSB set without single select"); // R4
        end
    end

endmodule

// File: rtl/radix4_pp_gen.sv
module radix4_pp_gen
    import radix4_pp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0]               x_in,
    input  logic [W-1:0]               y_in,
    output logic [W/2-1:0][W:0]        pp_rows,
    output logic [W/2-1:0]             pp_corr,
    output logic [2*W-1:0]             pp_bias
);

    localparam int ROWS = W / 2;
    localparam int PW   = 2 * W;

    function automatic logic [PW-1:0] bias_value();
        logic [PW-1:0] acc;
        acc = '0;
        for (int i = 0; i < ROWS; i++) begin
            acc = acc + ({{(PW-1){1'b0}}, 1'b1} << (W + 2 * i));
        end
        return (~acc) + 1'b1;
    endfunction

    localparam logic [PW-1:0] BIAS = bias_value();

    logic [W:0] y_pad;
    assign y_pad = {y_in, 1'b0};

    generate
        for (genvar i = 0; i < ROWS; i++) begin : g_row
            digit_ctl_t ctl_w;
            logic [W:0] row_w;
            logic       corr_w;

            radix4_digit_decode u_dec (
                .window_i (y_pad[2*i+2:2*i]),
                .ctl_o    (ctl_w)
            );

            radix4_row_build #(.W(W)) u_row (
                .x_i    (x_in),
                .ctl_i  (ctl_w),
                .row_o  (row_w),
                .corr_o (corr_w)
            );

            // Most significant row first.
            assign pp_rows[ROWS-1-i] = row_w;
            assign pp_corr[ROWS-1-i] = corr_w;

            always_comb begin
                if (ctl_w.two && !ctl_w.neg) begin
                    AST_DOUBLE_LSB_CLEAR: assert (!pp_rows[ROWS-1-i][0] && !pp_corr[ROWS-1-i])
                        else $error("positive double produced low residue"); // R2
                end
            end
        end
    endgenerate

    assign pp_bias = BIAS;

endmodule

// File: tb/radix4_pp_gen_test.sv
module radix4_pp_gen_test;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0]  x8, y8;
    logic [15:0] x16, y16;
    logic [3:0][8:0]   rows8;
    logic [3:0]        corr8;
    logic [15:0]       bias8;
    logic [7:0][16:0]  rows16;
    logic [7:0]        corr16;
    logic [31:0]       bias16;

    radix4_pp_gen #(.W(8)) uut (
        .x_in(x8), .y_in(y8), .pp_rows(rows8), .pp_corr(corr8), .pp_bias(bias8)
    );

    radix4_pp_gen #(.W(16)) uut16 (
        .x_in(x16), .y_in(y16), .pp_rows(rows16), .pp_corr(corr16), .pp_bias(bias16)
    );

    longint rbuf [8];
    longint cbuf [8];
    longint kbuf;

    task automatic tally(input bit ok, input string tag, input longint got, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic load8();
        for (int k = 0; k < 4; k++) begin
            rbuf[k] = longint'(rows8[k]);
            cbuf[k] = longint'(corr8[k]);
        end
        kbuf = longint'(bias8);
    endtask

    task automatic load16();
        for (int k = 0; k < 8; k++) begin
            rbuf[k] = longint'(rows16[k]);
            cbuf[k] = longint'(corr16[k]);
        end
        kbuf = longint'(bias16);
    endtask

    // Judges one operand pair of width n against arithmetic expectations.
    task automatic judge(input int n, input longint xs, input longint ys);
        int     nrows = n / 2;
        longint pmask = (64'sd1 << (2 * n)) - 1;
        longint rmask = (64'sd1 << (n + 1)) - 1;
        longint total = kbuf;
        longint kexp  = 0;
        for (int k = 0; k < nrows; k++) begin
            int     i  = nrows - 1 - k;
            longint b2 = (ys >> (2 * i + 1)) & 1;
            longint b1 = (ys >> (2 * i)) & 1;
            longint b0 = (i == 0) ? 0 : ((ys >> (2 * i - 1)) & 1);
            longint d  = -2 * b2 + b1 + b0;
            longint cn = ((d == -2) || (d == -1 && (xs & 1) == 0)) ? 1 : 0;
            longint v  = d * xs - 2 * cn;
            longint ex = (v & rmask) ^ (64'sd1 << n);
            if (d == 0)
                tally(rbuf[k] == ex && cbuf[k] == 0, $sformatf("R3 R7 zero-digit row %0d", i), rbuf[k], ex);
            else
                tally(rbuf[k] == ex, $sformatf("R1 R2 R4 R7 row %0d", i), rbuf[k], ex);
            tally(cbuf[k] == cn, $sformatf("R5 correction row %0d", i), cbuf[k], cn);
            total = total + (rbuf[k] << (2 * i)) + (cbuf[k] << (2 * i + 1));
            kexp  = kexp + (64'sd1 << (n + 2 * i));
        end
        kexp = (-kexp) & pmask;
        tally(kbuf == kexp, "R6 bias constant", kbuf, kexp);
        tally((total & pmask) == ((xs * ys) & pmask), "R8 product sum",
              total & pmask, (xs * ys) & pmask);
    endtask

    task automatic run8(input int a, input int b);
        @(posedge clk);
        x8 = a[7:0];
        y8 = b[7:0];
        @(negedge clk);
        load8();
        judge(8, longint'($signed(x8)), longint'($signed(y8)));
    endtask

    task automatic run16(input int a, input int b);
        @(posedge clk);
        x16 = a[15:0];
        y16 = b[15:0];
        @(negedge clk);
        load16();
        judge(16, longint'($signed(x16)), longint'($signed(y16)));
    endtask

    initial begin
        int corner [7] = '{32'h8000, 32'hFFFF, 0, 1, 32'h7FFF, 32'h5555, 32'hAAAA};
        x8 = '0; y8 = '0; x16 = '0; y16 = '0;
        repeat (3) @(posedge clk);
        // Quiescent state: zero operands give all-zero-digit rows (R3).
        @(negedge clk);
        load8();
        judge(8, 0, 0);
        // Full sweep at width 8.
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b++) begin
                run8(a, b);
            end
        end
        // Corner crosses at width 16, including most negative values (R8).
        for (int p = 0; p < 7; p++) begin
            for (int q = 0; q < 7; q++) begin
                run16(corner[p], corner[q]);
            end
        end
        for (int r = 0; r < 1500; r++) begin
            run16(int'($urandom), int'($urandom));
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired before completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule